// File: doc/BRIEF.md
# Embedded-Clock Frame Deserializer

This block takes a serial bit stream, one bit per clock, in which every word travels inside a ten-bit frame. Each frame opens with a single embedded clock period, a one followed by a zero, and eight data bits follow most significant bit first. The serial stream has no separate clock or framing line, so the deserializer takes its word alignment from the rising edge that each frame start carries.

After reset the block searches the stream for a zero-to-one step and treats it as the start of a candidate frame. It then follows the ten-bit frame grid and checks the opening one-zero pair of every frame. Enough good frames in a row make it declare lock. From then on each well-formed frame is copied out of the shift register into a separate holding register, and a one-cycle valid pulse goes with each copy. Missing headers make the block give up the grid and search again. A word-rate strobe, derived by dividing the bit timing by ten, marks the end of every frame on the followed grid.

Top module: `ecd_deser`

## Requirements
- R1: While `rst` is high on a clock edge, the next cycle shows `locked`, `word_valid` and `word_strobe` low and `word_out` equal to zero.
- R2: While searching, a `ser_in` value of 0 followed on the next edge by 1 makes that 1 bit 0 of a candidate frame. A frame is ten consecutive bits: bit 0 must be 1, bit 1 must be 0, and bits 2 to 9 carry the data word most significant bit first.
- R3: Lock is declared after four consecutive frames on the grid have a good header, the candidate frame counted as the first. `locked` rises in the cycle after the last bit of the fourth frame.
- R4: Before lock, one frame with a bad header abandons the grid. The block searches again, and the good-frame count starts over at the next candidate.
- R5: A good-header frame whose last bit arrives while `locked` is already high puts its data on `word_out` and pulses `word_valid` high for exactly one cycle, in the cycle after its last bit. No pulse occurs at any other time.
- R6: While locked, a single bad-header frame produces no pulse and keeps `locked` high. Two consecutive bad-header frames drop `locked` in the cycle after the second frame's last bit and restart the search. A good frame between two bad ones clears the miss count.
- R7: `word_strobe` pulses for one cycle after the last bit of every frame on the followed grid, good or bad, and stays low while searching.
- R8: `word_out` holds its value in every cycle without a `word_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data, already sampled at bit rate |
| word_out | output | 8 | Holding register with the last delivered word |
| word_valid | output | 1 | One-cycle pulse when `word_out` is loaded |
| locked | output | 1 | Frame alignment is locked |
| word_strobe | output | 1 | Word-rate strobe at each frame end on the grid |

## Verification
The hardest situation to reach from the ports is a false alignment: data bits that contain a zero-to-one step, seized while searching, with the block then walking a wrong grid until a header check fails. The random stimulus sends real frames mixed with gap bits of random length and random corrupted headers. This regularly shifts the stream against the grid the block is following and forces it through search, verification and loss at arbitrary phases. A per-bit reference model in the bench tracks each of these paths. Directed sequences cover the exact frame counts at which lock is gained, and the single-miss and double-miss cases while locked.

// File: rtl/ecd_pkg.sv
package ecd_pkg;

    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_VERIFY = 2'd1,
        ST_LOCKED = 2'd2
    } align_state_t;

    // Frame-end event carried from the datapath to the alignment controller
    typedef struct packed {
        logic last_bit;
        logic hdr_ok;
    } frame_evt_t;

    localparam int unsigned HDR_BITS = 2;

    // A header is good when the embedded clock shows high then low
    function automatic logic header_good(input logic first_bit, input logic second_bit);
        return first_bit & ~second_bit;
    endfunction

endpackage

// File: rtl/ecd_edge_hunt.sv
module ecd_edge_hunt (
    input  logic clk,
    input  logic rst,
    input  logic ser_in,
    input  logic hunting,
    output logic cand_start
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= ser_in;
    end

    assign cand_start = hunting & ~prev_q & ser_in;
endmodule

// File: rtl/ecd_bit_counter.sv
module ecd_bit_counter #(
    parameter int unsigned FRAME_W = 10,
    localparam int unsigned POS_W  = $clog2(FRAME_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cand_start,
    input  logic             aligned,
    output logic [POS_W-1:0] pos,
    output logic             last_bit,
    output logic             word_strobe
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_W - 1);

    logic [POS_W-1:0] pos_q;

    assign pos      = pos_q;
    assign last_bit = aligned & (pos_q == LAST_POS);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q       <= '0;
            word_strobe <= 1'b0;
        end else begin
            word_strobe <= last_bit;
            if (cand_start)
                pos_q <= POS_W'(1);
            else if (aligned)
                pos_q <= (pos_q == LAST_POS) ? '0 : pos_q + POS_W'(1);
            else
                pos_q <= '0;
        end
    end
endmodule

// File: rtl/ecd_frame_shift.sv
module ecd_frame_shift
    import ecd_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned POS_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_in,
    input  logic              cand_start,
    input  logic              aligned,
    input  logic [POS_W-1:0]  pos,
    output logic              hdr_ok,
    output logic [DATA_W-1:0] word_next
);
    logic              first_q;
    logic              hdr_q;
    logic [DATA_W-2:0] shift_q;

    assign hdr_ok    = hdr_q;
    assign word_next = {shift_q, ser_in};

    always_ff @(posedge clk) begin
        if (rst) begin
            first_q <= 1'b0;
            hdr_q   <= 1'b0;
            shift_q <= '0;
        end else if (cand_start) begin
            first_q <= 1'b1;
        end else if (aligned) begin
            if (pos == POS_W'(0))
                first_q <= ser_in;
            else if (pos == POS_W'(1))
                hdr_q <= header_good(first_q, ser_in);
            else if (pos >= POS_W'(HDR_BITS))
                shift_q <= {shift_q[DATA_W-3:0], ser_in};
        end
    end
endmodule

// File: rtl/ecd_lock_fsm.sv
module ecd_lock_fsm
    import ecd_pkg::*;
#(
    parameter int unsigned LOCK_FRAMES = 4,
    parameter int unsigned DROP_FRAMES = 2,
    localparam int unsigned GOOD_W = $clog2(LOCK_FRAMES + 1),
    localparam int unsigned MISS_W = $clog2(DROP_FRAMES + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cand_start,
    input  frame_evt_t   evt,
    output align_state_t state,
    output logic         deliver
);
    align_state_t      state_q;
    logic [GOOD_W-1:0] good_q;
    logic [MISS_W-1:0] miss_q;

    assign state   = state_q;
    assign deliver = (state_q == ST_LOCKED) & evt.last_bit & evt.hdr_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HUNT;
            good_q  <= '0;
            miss_q  <= '0;
        end else begin
            unique case (state_q)
                ST_HUNT: begin
                    if (cand_start) begin
                        state_q <= ST_VERIFY;
                        good_q  <= '0;
                    end
                end
                ST_VERIFY: begin
                    if (evt.last_bit) begin
                        if (!evt.hdr_ok) begin
                            state_q <= ST_HUNT;
                        end else if (good_q == GOOD_W'(LOCK_FRAMES - 1)) begin
                            state_q <= ST_LOCKED;
                            miss_q  <= '0;
                        end else begin
                            good_q <= good_q + GOOD_W'(1);
                        end
                    end
                end
                ST_LOCKED: begin
                    if (evt.last_bit) begin
                        if (evt.hdr_ok) begin
                            miss_q <= '0;
                        end else if (miss_q == MISS_W'(DROP_FRAMES - 1)) begin
                            state_q <= ST_HUNT;
                        end else begin
                            miss_q <= miss_q + MISS_W'(1);
                        end
                    end
                end
                default: state_q <= ST_HUNT;
            endcase
        end
    end
endmodule

// File: rtl/ecd_hold_reg.sv
module ecd_hold_reg #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              deliver,
    input  logic [DATA_W-1:0] word_next,
    output logic [DATA_W-1:0] word_out,
    output logic              word_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word_out   <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= deliver;
            if (deliver) word_out <= word_next;
        end
    end
endmodule

// File: rtl/ecd_deser.sv
module ecd_deser
    import ecd_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned LOCK_FRAMES = 4,
    parameter int unsigned DROP_FRAMES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_in,
    output logic [DATA_W-1:0] word_out,
    output logic              word_valid,
    output logic              locked,
    output logic              word_strobe
);
    localparam int unsigned FRAME_W = DATA_W + HDR_BITS;
    localparam int unsigned POS_W   = $clog2(FRAME_W);

    align_state_t      state;
    logic              hunting;
    logic              aligned;
    logic              cand_start;
    logic [POS_W-1:0]  pos;
    logic              last_bit;
    logic              hdr_ok;
    logic [DATA_W-1:0] word_next;
    logic              deliver;
    frame_evt_t        evt;

    assign hunting = (state == ST_HUNT);
    assign aligned = ~hunting;
    assign locked  = (state == ST_LOCKED);
    assign evt     = '{last_bit: last_bit, hdr_ok: hdr_ok};

    ecd_edge_hunt u_hunt (
        .clk        (clk),
        .rst        (rst),
        .ser_in     (ser_in),
        .hunting    (hunting),
        .cand_start (cand_start)
    );

    ecd_bit_counter #(.FRAME_W(FRAME_W)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .cand_start  (cand_start),
        .aligned     (aligned),
        .pos         (pos),
        .last_bit    (last_bit),
        .word_strobe (word_strobe)
    );

    ecd_frame_shift #(.DATA_W(DATA_W), .POS_W(POS_W)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .ser_in     (ser_in),
        .cand_start (cand_start),
        .aligned    (aligned),
        .pos        (pos),
        .hdr_ok     (hdr_ok),
        .word_next  (word_next)
    );

    ecd_lock_fsm #(.LOCK_FRAMES(LOCK_FRAMES), .DROP_FRAMES(DROP_FRAMES)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .cand_start (cand_start),
        .evt        (evt),
        .state      (state),
        .deliver    (deliver)
    );

    ecd_hold_reg #(.DATA_W(DATA_W)) u_hold (
        .clk        (clk),
        .rst        (rst),
        .deliver    (deliver),
        .word_next  (word_next),
        .word_out   (word_out),
        .word_valid (word_valid)
    );
endmodule

// File: rtl/ecd_deser_chk.sv
module ecd_deser_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] word_out,
    input logic              word_valid,
    input logic              locked,
    input logic              word_strobe
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!locked && !word_valid && !word_strobe && word_out == '0));

    // R5
    valid_needs_lock_chk: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> (locked && $past(locked)));

    // R5
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid);

    // R5
    valid_at_frame_end_chk: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> word_strobe);

    // R7
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        word_strobe |=> !word_strobe);

    // R3
    lock_rise_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> word_strobe);

    // R6
    lock_fall_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> (word_strobe && !word_valid));

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !word_valid |-> $stable(word_out));
endmodule

bind ecd_deser ecd_deser_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .word_out    (word_out),
    .word_valid  (word_valid),
    .locked      (locked),
    .word_strobe (word_strobe)
);

// File: tb/ecd_deser_bench.sv
module ecd_deser_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_in = 1'b0;
    logic [7:0] word_out;
    logic       word_valid, locked, word_strobe;

    always #5 clk = ~clk;

    ecd_deser u_ecd_deser (
        .clk(clk), .rst(rst), .ser_in(ser_in),
        .word_out(word_out), .word_valid(word_valid),
        .locked(locked), .word_strobe(word_strobe)
    );

    int checks = 0;
    int errors = 0;

    // reference model: 0 searching, 1 verifying, 2 locked
    int       m_st, m_idx, m_good, m_miss;
    bit       m_prev;
    bit       m_fr[10];
    bit [7:0] m_word;
    bit       m_valid, m_strobe;

    // outputs seen at the last sample, and those seen at a frame's first bit
    bit [7:0] pre_word;
    bit       pre_valid, pre_locked, pre_strobe;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_st = 0; m_idx = 0; m_good = 0; m_miss = 0; m_prev = 1'b1;
        m_word = 8'h00; m_valid = 1'b0; m_strobe = 1'b0;
    endtask

    task automatic model_step(input bit b);
        bit ok;
        bit end_now;
        end_now = 1'b0;
        ok = 1'b0;
        m_valid = 1'b0;
        m_strobe = 1'b0;
        if (m_st == 0) begin
            if (!m_prev && b) begin
                m_st = 1; m_idx = 1; m_fr[0] = 1'b1; m_good = 0;
            end
        end else begin
            m_fr[m_idx] = b;
            if (m_idx == 9) begin
                end_now = 1'b1;
                m_idx = 0;
            end else begin
                m_idx++;
            end
        end
        m_prev = b;
        if (end_now) begin
            m_strobe = 1'b1;
            ok = m_fr[0] && !m_fr[1];
            if (m_st == 1) begin
                if (!ok) m_st = 0;
                else begin
                    m_good++;
                    if (m_good == 4) begin m_st = 2; m_miss = 0; end
                end
            end else begin
                if (ok) begin
                    for (int j = 2; j < 10; j++) m_word = {m_word[6:0], m_fr[j]};
                    m_valid = 1'b1;
                    m_miss = 0;
                end else begin
                    m_miss++;
                    if (m_miss == 2) m_st = 0;
                end
            end
        end
    endtask

    // sample outputs at the falling edge, compare, then present the next bit
    task automatic step(input bit b);
        @(negedge clk);
        pre_word = word_out; pre_valid = word_valid;
        pre_locked = locked; pre_strobe = word_strobe;
        chk(word_valid == m_valid, "R5", "word_valid", word_valid, m_valid);
        chk(locked == (m_st == 2), "R3", "locked", locked, (m_st == 2));
        chk(word_strobe == m_strobe, "R7", "word_strobe", word_strobe, m_strobe);
        chk(word_out == m_word, "R8", "word_out", word_out, m_word);
        ser_in = b;
        model_step(b);
    endtask

    bit [7:0] f_word;
    bit       f_valid, f_locked, f_strobe;

    // sends one frame; f_* hold the outputs seen just before its first bit took effect
    task automatic send_frame(input bit [1:0] hdr, input bit [7:0] d);
        step(hdr[1]);
        f_word = pre_word; f_valid = pre_valid; f_locked = pre_locked; f_strobe = pre_strobe;
        step(hdr[0]);
        for (int i = 7; i >= 0; i--) step(d[i]);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        ser_in = 1'b0;
        repeat (3) @(negedge clk);
        // R1: outputs cleared while reset is applied
        chk(!locked && !word_valid && !word_strobe && word_out == 8'h00, "R1",
            "reset outputs", {locked, word_valid, word_strobe, word_out}, 0);
        model_reset();
        rst = 1'b0;
        model_step(1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1c0de));

        // Directed: lock, delivery, single miss, double miss
        do_reset();
        step(1'b0);
        chk(!word_strobe, "R7", "no strobe while searching", word_strobe, 0);
        send_frame(2'b10, 8'h11);
        send_frame(2'b10, 8'h22);
        send_frame(2'b10, 8'h33);
        send_frame(2'b10, 8'h44);
        chk(!f_locked, "R3", "unlocked after three frames", f_locked, 0);
        send_frame(2'b10, 8'hA5);
        chk(f_locked, "R3", "locked after four frames", f_locked, 1);
        chk(!f_valid, "R5", "lock frame not delivered", f_valid, 0);
        send_frame(2'b10, 8'hFF);
        chk(f_valid && f_word == 8'hA5, "R2", "first word MSB first", f_word, 8'hA5);
        chk(f_strobe, "R7", "strobe at frame end", f_strobe, 1);
        send_frame(2'b00, 8'h00);
        chk(f_word == 8'hFF, "R5", "all-ones word", f_word, 8'hFF);
        send_frame(2'b10, 8'h00);
        chk(f_locked && !f_valid && f_word == 8'hFF, "R6", "single miss keeps lock",
            {f_locked, f_valid, f_word}, {1'b1, 1'b0, 8'hFF});
        send_frame(2'b11, 8'h5A);
        chk(f_valid && f_word == 8'h00, "R6", "good frame after miss delivered", f_word, 8'h00);
        send_frame(2'b00, 8'h00);
        chk(f_locked, "R6", "still locked after one miss", f_locked, 1);
        send_frame(2'b10, 8'h77);
        chk(!f_locked && !f_valid, "R6", "lock dropped after two misses", f_locked, 0);

        // Directed: header failure during verification restarts the count
        do_reset();
        step(1'b0);
        send_frame(2'b10, 8'h10);
        send_frame(2'b10, 8'h20);
        send_frame(2'b11, 8'h00);
        send_frame(2'b10, 8'h30);
        send_frame(2'b10, 8'h40);
        send_frame(2'b10, 8'h50);
        send_frame(2'b10, 8'h60);
        chk(!f_locked, "R4", "count restarted after bad frame", f_locked, 0);
        send_frame(2'b10, 8'h3C);
        chk(f_locked, "R4", "lock after four fresh frames", f_locked, 1);

        // Random: frames, corrupted headers and misaligning gap bits
        do_reset();
        for (int n = 0; n < 400; n++) begin
            int r;
            bit [1:0] hdr;
            r = int'($urandom % 16);
            if (r == 0) begin
                int g;
                g = int'($urandom % 3) + 1;
                for (int k = 0; k < g; k++) step(1'($urandom));
            end
            hdr = 2'b10;
            if (r == 1) hdr = 2'b00;
            if (r == 2) hdr = 2'b11;
            if (r == 3) hdr = 2'b01;
            send_frame(hdr, 8'($urandom));
        end
        repeat (12) step(1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule